// File: doc/BRIEF.md
# Delayed A/B Trigger Sequencer with Holdoff

This block sits after the analog comparators and slope stages of a sampling acquisition front end. Each source input carries a one-cycle pulse that has already been qualified for level and slope. The sequencer picks one source as the A trigger and one as the B trigger. It then either accepts A alone, or arms B after A and waits for B. B can be delayed by a number of clock cycles or by a number of B events. When the qualifying trigger is accepted, the sequencer opens the trigger gate for the running acquisition and pulses the control that starts the jitter-measurement ramp.

Once the acquisition signals completion, a holdoff interval keeps the sequencer from re-arming. The holdoff floor comes from a timebase register, and a user extension register is added on top of it. All settings are loaded through a small register write port. Writes are only honoured while nothing is in flight, so a trigger sequence always runs on one consistent configuration.

Top module: `trig_sequencer`

## Requirements
- R1: After reset `armed` is high and `trig_gate`, `ramp_start`, `b_wait` and `holdoff_active` are low. Default configuration: A source CH1 (select 0), B source CH2 (select 1), mode A-only, time delay 0, event count 0, holdoff minimum 0, holdoff extension 0.
- R2: In mode 0 (A-only) or mode 3 (treated as A-only), a pulse on the selected A source that is sampled at a rising edge while `armed` is high raises `trig_gate` in the next cycle.
- R3: `ramp_start` is high for exactly the first cycle in which `trig_gate` is high, and is low at all other times.
- R4: Source selects are 3-bit codes: 0=CH1, 1=CH2, 2=EXT1, 3=EXT2, 4=LINE, mapped to `src_trig` bits 0 to 4. Codes 5, 6 and 7 select no source, so no trigger is ever accepted on them.
- R5: While `trig_gate` is high, further source pulses are ignored. `trig_gate` falls in the cycle after `acq_done` is sampled high. A pulse on `acq_done` at any other time has no effect.
- R6: After `trig_gate` falls, `holdoff_active` stays high and source pulses are ignored. `armed` returns only after the holdoff ends.
- R7: `holdoff_active` stays high for exactly min + ext + 1 cycles. The sum saturates at 2^24-1, so the user extension can never shorten the interval below the minimum.
- R8: In mode 1 (B after time), accepting A raises `b_wait`. A B pulse sampled at the k-th rising edge after the A edge is ignored for k ≤ D, where D is the time delay. The first B pulse with k ≥ D+1 raises `trig_gate` in the next cycle.
- R9: In mode 2 (B after events), accepting A raises `b_wait`. The first N B pulses are discarded, where N is the event count, and the (N+1)-th raises `trig_gate` in the next cycle. Idle cycles between B pulses do not change the count.
- R10: A pulse on the A source while `b_wait` is high has no effect. Only the selected B source can end the wait.
- R11: Configuration writes are applied only while `armed` or `holdoff_active` is high. A write during `b_wait` or `trig_gate` is dropped.
- R12: Register addresses: 0 A source, 1 B source, 2 mode, 3 time delay (16 bits), 4 event count (16 bits), 5 holdoff minimum (24 bits), 6 holdoff extension (24 bits). A write to address 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_trig | input | 5 | Qualified per-source trigger pulses, bit 0 CH1 to bit 4 LINE |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 24 | Configuration write data |
| acq_done | input | 1 | Acquisition complete pulse |
| trig_gate | output | 1 | High while the triggered acquisition runs |
| ramp_start | output | 1 | One-cycle start of the jitter-measurement ramp |
| armed | output | 1 | Waiting for the A trigger |
| b_wait | output | 1 | A accepted, waiting for the delayed B trigger |
| holdoff_active | output | 1 | Holdoff interval in progress |

## Verification
The hardest situation to reach is the exact boundary where a B pulse coincides with the last cycle of the time delay, or with the last discarded event. One cycle either way changes whether the trigger is taken. The bench reaches it by accepting A and then presenting B on every following edge, checking the gate after each one, so the first accepted edge is pinned to D+1. The second hard case is a configuration write that lands inside a blocked phase. The bench issues writes mid-acquisition and mid-delay, then proves that the old source still triggers and the new one does not once the sequencer re-arms.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

   typedef enum logic [1:0] {
      ST_ARM   = 2'd0,
      ST_BWAIT = 2'd1,
      ST_ACQ   = 2'd2,
      ST_HOLD  = 2'd3
   } seq_state_e;

   typedef enum logic [1:0] {
      MD_A_ONLY   = 2'd0,
      MD_B_TIME   = 2'd1,
      MD_B_EVENTS = 2'd2,
      MD_RSVD     = 2'd3
   } dly_mode_e;

   localparam int CFG_ADDR_W = 3;

   localparam logic [CFG_ADDR_W-1:0] RA_A_SRC   = 3'd0;
   localparam logic [CFG_ADDR_W-1:0] RA_B_SRC   = 3'd1;
   localparam logic [CFG_ADDR_W-1:0] RA_MODE    = 3'd2;
   localparam logic [CFG_ADDR_W-1:0] RA_DLY_T   = 3'd3;
   localparam logic [CFG_ADDR_W-1:0] RA_DLY_EV  = 3'd4;
   localparam logic [CFG_ADDR_W-1:0] RA_HO_MIN  = 3'd5;
   localparam logic [CFG_ADDR_W-1:0] RA_HO_EXT  = 3'd6;

endpackage

// File: rtl/trig_src_pick.sv
module trig_src_pick #(
   parameter int NUM_SRC = 5,
   parameter int SEL_W   = 3
) (
   input  logic [NUM_SRC-1:0] pulses,
   input  logic [SEL_W-1:0]   sel,
   output logic               hit
);

   logic [NUM_SRC-1:0] match;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_match
      assign match[i] = pulses[i] && (sel == SEL_W'(i));
   end

   assign hit = |match;

   // R4: codes beyond the source count never produce a hit
   always_comb begin
      if (int'(sel) >= NUM_SRC) begin
         a_r4_no_src : assert (!hit);
      end
   end

endmodule

// File: rtl/trig_down_cnt.sv
module trig_down_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (dec && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

   // R7/R8: once expired the counter stays expired until reloaded
   a_r7_zero_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (zero && !load) |=> zero);

   // R8: a load of a non-zero value is never seen as expired next cycle
   a_r8_load_nonzero : assert property (@(posedge clk) disable iff (!rst_n)
      (load && (load_val != '0)) |=> !zero);

endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer
   import trig_seq_pkg::*;
#(
   parameter int NUM_SRC = 5,
   parameter int DLY_W   = 16,
   parameter int HOLD_W  = 24,
   parameter int CFG_W   = 24
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_SRC-1:0]    src_trig,
   input  logic                  cfg_we,
   input  logic [CFG_ADDR_W-1:0] cfg_addr,
   input  logic [CFG_W-1:0]      cfg_wdata,
   input  logic                  acq_done,
   output logic                  trig_gate,
   output logic                  ramp_start,
   output logic                  armed,
   output logic                  b_wait,
   output logic                  holdoff_active
);

   localparam int SEL_W = $clog2(NUM_SRC + 1);

   if (NUM_SRC < 2) begin : g_chk_src
      $error("trig_sequencer: NUM_SRC must be at least 2");
   end
   if (CFG_W < HOLD_W || CFG_W < DLY_W || CFG_W < SEL_W) begin : g_chk_cfg
      $error("trig_sequencer: CFG_W narrower than a configuration field");
   end
   if (HOLD_W < 2 || DLY_W < 1) begin : g_chk_cnt
      $error("trig_sequencer: counter width too small");
   end

   // configuration
   logic [SEL_W-1:0]  a_src_q, b_src_q;
   dly_mode_e         mode_q;
   logic [DLY_W-1:0]  dly_time_q, dly_events_q;
   logic [HOLD_W-1:0] ho_min_q, ho_ext_q;

   seq_state_e state_q, state_d;
   logic       cfg_open;

   assign cfg_open = (state_q == ST_ARM) || (state_q == ST_HOLD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_src_q      <= SEL_W'(0);
         b_src_q      <= SEL_W'(1);
         mode_q       <= MD_A_ONLY;
         dly_time_q   <= '0;
         dly_events_q <= '0;
         ho_min_q     <= '0;
         ho_ext_q     <= '0;
      end else if (cfg_we && cfg_open) begin
         case (cfg_addr)
            RA_A_SRC:  a_src_q      <= cfg_wdata[SEL_W-1:0];
            RA_B_SRC:  b_src_q      <= cfg_wdata[SEL_W-1:0];
            RA_MODE:   mode_q       <= dly_mode_e'(cfg_wdata[1:0]);
            RA_DLY_T:  dly_time_q   <= cfg_wdata[DLY_W-1:0];
            RA_DLY_EV: dly_events_q <= cfg_wdata[DLY_W-1:0];
            RA_HO_MIN: ho_min_q     <= cfg_wdata[HOLD_W-1:0];
            RA_HO_EXT: ho_ext_q     <= cfg_wdata[HOLD_W-1:0];
            default:   ;
         endcase
      end
   end

   // source selection
   logic a_hit, b_hit;

   trig_src_pick #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_pick_a (
      .pulses (src_trig),
      .sel    (a_src_q),
      .hit    (a_hit)
   );

   trig_src_pick #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_pick_b (
      .pulses (src_trig),
      .sel    (b_src_q),
      .hit    (b_hit)
   );

   // delay counter, shared by time and event modes
   logic time_mode, b_delayed;
   logic dly_load, dly_dec, dly_zero, b_accept;

   assign time_mode = (mode_q == MD_B_TIME);
   assign b_delayed = (mode_q == MD_B_TIME) || (mode_q == MD_B_EVENTS);
   assign dly_load  = (state_q == ST_ARM) && a_hit;
   assign dly_dec   = (state_q == ST_BWAIT) && (time_mode || b_hit);
   assign b_accept  = (state_q == ST_BWAIT) && b_hit && dly_zero;

   trig_down_cnt #(.W(DLY_W)) u_dly (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (dly_load),
      .load_val (time_mode ? dly_time_q : dly_events_q),
      .dec      (dly_dec),
      .zero     (dly_zero)
   );

   // holdoff: floor plus user extension, saturating
   logic [HOLD_W:0]   ho_sum_wide;
   logic [HOLD_W-1:0] ho_len;
   logic              ho_load, ho_zero;

   assign ho_sum_wide = {1'b0, ho_min_q} + {1'b0, ho_ext_q};
   assign ho_len      = ho_sum_wide[HOLD_W] ? '1 : ho_sum_wide[HOLD_W-1:0];
   assign ho_load     = (state_q == ST_ACQ) && acq_done;

   trig_down_cnt #(.W(HOLD_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ho_load),
      .load_val (ho_len),
      .dec      (state_q == ST_HOLD),
      .zero     (ho_zero)
   );

   // sequencing
   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_ARM:   if (a_hit)    state_d = b_delayed ? ST_BWAIT : ST_ACQ;
         ST_BWAIT: if (b_accept) state_d = ST_ACQ;
         ST_ACQ:   if (acq_done) state_d = ST_HOLD;
         ST_HOLD:  if (ho_zero)  state_d = ST_ARM;
         default:                state_d = ST_ARM;
      endcase
   end

   logic ramp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_ARM;
         ramp_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         ramp_q  <= (state_d == ST_ACQ) && (state_q != ST_ACQ);
      end
   end

   assign trig_gate      = (state_q == ST_ACQ);
   assign ramp_start     = ramp_q;
   assign armed          = (state_q == ST_ARM);
   assign b_wait         = (state_q == ST_BWAIT);
   assign holdoff_active = (state_q == ST_HOLD);

   // R3: ramp start marks only the opening cycle of the gate
   a_r3_ramp_in_gate : assert property (@(posedge clk) disable iff (!rst_n)
      ramp_start |-> trig_gate);
   a_r3_ramp_on_rise : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trig_gate) |-> ramp_start);
   a_r3_ramp_single : assert property (@(posedge clk) disable iff (!rst_n)
      ramp_start |=> !ramp_start);

   // R5: the acquisition runs until completion is signalled
   a_r5_gate_held : assert property (@(posedge clk) disable iff (!rst_n)
      (trig_gate && !acq_done) |=> trig_gate);

   // R6: holdoff follows only a completed acquisition
   a_r6_hold_entry : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(holdoff_active) |-> $past(trig_gate && acq_done));

   // R7: holdoff never ends while its timer is still running
   a_r7_hold_runs : assert property (@(posedge clk) disable iff (!rst_n)
      (holdoff_active && !ho_zero) |=> holdoff_active);

   // R8/R9: B cannot be accepted before the delay counter expires
   a_r8_no_early_b : assert property (@(posedge clk) disable iff (!rst_n)
      (b_wait && !dly_zero) |=> !trig_gate);

   // R11: configuration is frozen while a trigger sequence is in flight
   a_r11_cfg_frozen : assert property (@(posedge clk) disable iff (!rst_n)
      (b_wait || trig_gate) |=> ($stable(a_src_q) && $stable(b_src_q) &&
                                 $stable(mode_q) && $stable(dly_time_q) &&
                                 $stable(dly_events_q) && $stable(ho_min_q) &&
                                 $stable(ho_ext_q)));

endmodule

// File: tb/trig_sequencer_test.sv
module trig_sequencer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  src_trig = '0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [23:0] cfg_wdata = '0;
   logic        acq_done = 1'b0;
   logic        trig_gate, ramp_start, armed, b_wait, holdoff_active;

   int vecs = 0;
   int errs = 0;
   bit done_flag = 1'b0;

   always #10 clk = ~clk;

   trig_sequencer uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .src_trig       (src_trig),
      .cfg_we         (cfg_we),
      .cfg_addr       (cfg_addr),
      .cfg_wdata      (cfg_wdata),
      .acq_done       (acq_done),
      .trig_gate      (trig_gate),
      .ramp_start     (ramp_start),
      .armed          (armed),
      .b_wait         (b_wait),
      .holdoff_active (holdoff_active)
   );

   task automatic chk(input string req, input int act, input int exp);
      vecs++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input int addr, input int data);
      cfg_we    = 1'b1;
      cfg_addr  = addr[2:0];
      cfg_wdata = data[23:0];
      cyc();
      cfg_we    = 1'b0;
   endtask

   task automatic pulse(input logic [4:0] m);
      src_trig = m;
      cyc();
      src_trig = '0;
   endtask

   task automatic finish_acq();
      acq_done = 1'b1;
      cyc();
      acq_done = 1'b0;
      for (int i = 0; i < 200 && !armed; i++) cyc();
   endtask

   task automatic t_reset();
      chk("R1 armed", armed, 1);
      chk("R1 gate", trig_gate, 0);
      chk("R1 ramp", ramp_start, 0);
      chk("R1 b_wait", b_wait, 0);
      chk("R1 holdoff", holdoff_active, 0);
      pulse(5'b00010);
      chk("R1 default A source CH1 ignores CH2", trig_gate, 0);
      pulse(5'b00001);
      chk("R1 default A-only on CH1", trig_gate, 1);
      finish_acq();
   endtask

   task automatic t_a_only();
      acq_done = 1'b1; cyc(); acq_done = 1'b0;
      chk("R5 acq_done while armed ignored", armed, 1);
      chk("R5 acq_done while armed no holdoff", holdoff_active, 0);
      pulse(5'b00001);
      chk("R2 gate after A", trig_gate, 1);
      chk("R3 ramp first cycle", ramp_start, 1);
      cyc();
      chk("R3 ramp single cycle", ramp_start, 0);
      chk("R5 gate held", trig_gate, 1);
      pulse(5'b11111);
      chk("R5 pulses in acquisition ignored", trig_gate, 1);
      chk("R3 no second ramp", ramp_start, 0);
      acq_done = 1'b1; cyc(); acq_done = 1'b0;
      chk("R5 gate falls after done", trig_gate, 0);
      chk("R6 holdoff follows", holdoff_active, 1);
      cyc();
      chk("R7 zero holdoff lasts one cycle", armed, 1);
      wr(2, 3);
      pulse(5'b00001);
      chk("R2 mode 3 behaves as A-only", trig_gate, 1);
      finish_acq();
      wr(2, 0);
   endtask

   task automatic t_src_sel();
      for (int k = 0; k < 8; k++) begin
         wr(0, k);
         for (int j = 0; j < 5; j++) begin
            if (j != k) begin
               pulse(5'(1 << j));
               chk($sformatf("R4 sel %0d ignores bit %0d", k, j), trig_gate, 0);
            end
         end
         if (k < 5) begin
            pulse(5'(1 << k));
            chk($sformatf("R4 sel %0d triggers", k), trig_gate, 1);
            finish_acq();
         end else begin
            pulse(5'b11111);
            chk($sformatf("R4 sel %0d selects nothing", k), trig_gate, 0);
         end
      end
      wr(0, 0);
   endtask

   task automatic measure_hold(input int mn, input int ex);
      int n;
      wr(5, mn);
      wr(6, ex);
      pulse(5'b00001);
      acq_done = 1'b1; cyc(); acq_done = 1'b0;
      n = 0;
      for (int i = 0; i < 500 && holdoff_active; i++) begin
         n++;
         cyc();
      end
      chk($sformatf("R7 holdoff length min %0d ext %0d", mn, ex), n, mn + ex + 1);
      chk("R6 armed after holdoff", armed, 1);
   endtask

   task automatic t_holdoff();
      wr(5, 5);
      wr(6, 3);
      pulse(5'b00001);
      acq_done = 1'b1; cyc(); acq_done = 1'b0;
      for (int i = 1; i <= 8; i++) begin
         pulse(5'b11111);
         chk("R6 holdoff held under pulses", holdoff_active, 1);
         chk("R6 pulse in holdoff ignored", trig_gate, 0);
      end
      pulse(5'b11111);
      chk("R6 holdoff ends", armed, 1);
      chk("R6 last holdoff pulse ignored", trig_gate, 0);
      measure_hold(4, 0);
      measure_hold(2, 7);
      measure_hold(0, 6);
      wr(5, 0);
      wr(6, 0);
   endtask

   task automatic t_time_delay(input int d);
      wr(2, 1);
      wr(3, d);
      wr(1, 1);
      pulse(5'b00001);
      chk("R8 b_wait after A", b_wait, 1);
      chk("R8 no gate on A", trig_gate, 0);
      for (int i = 1; i <= d; i++) begin
         pulse(5'b00011);
         chk($sformatf("R8 B at edge %0d of delay %0d ignored", i, d), trig_gate, 0);
         chk("R10 A in wait ignored", b_wait, 1);
      end
      pulse(5'b00010);
      chk($sformatf("R8 B at edge %0d triggers", d + 1), trig_gate, 1);
      chk("R3 ramp on B", ramp_start, 1);
      finish_acq();
   endtask

   task automatic t_time_late();
      wr(2, 1);
      wr(3, 2);
      pulse(5'b00001);
      cyc(6);
      chk("R8 waits for B past delay", b_wait, 1);
      pulse(5'b00001);
      chk("R10 A source cannot end wait", trig_gate, 0);
      pulse(5'b00010);
      chk("R8 late B triggers", trig_gate, 1);
      finish_acq();
   endtask

   task automatic t_event_delay(input int n);
      wr(2, 2);
      wr(4, n);
      pulse(5'b00001);
      chk("R9 b_wait after A", b_wait, 1);
      for (int i = 1; i <= n; i++) begin
         pulse(5'b00010);
         chk($sformatf("R9 B event %0d of %0d discarded", i, n), trig_gate, 0);
         cyc(3);
         chk("R9 idle cycles keep waiting", b_wait, 1);
      end
      pulse(5'b00010);
      chk($sformatf("R9 B event %0d triggers", n + 1), trig_gate, 1);
      finish_acq();
   endtask

   task automatic t_cfg_lock();
      wr(2, 0);
      wr(0, 0);
      wr(5, 3);
      pulse(5'b00001);
      wr(0, 1);
      finish_acq();
      pulse(5'b00010);
      chk("R11 write in acquisition dropped", trig_gate, 0);
      pulse(5'b00001);
      chk("R11 old source kept", trig_gate, 1);
      acq_done = 1'b1; cyc(); acq_done = 1'b0;
      wr(0, 2);
      for (int i = 0; i < 50 && !armed; i++) cyc();
      pulse(5'b00001);
      chk("R11 write in holdoff applied old source gone", trig_gate, 0);
      pulse(5'b00100);
      chk("R11 write in holdoff applied", trig_gate, 1);
      finish_acq();
      wr(0, 0);
      wr(2, 1);
      wr(3, 3);
      wr(1, 1);
      pulse(5'b00001);
      wr(1, 3);
      cyc(5);
      pulse(5'b01000);
      chk("R11 write in b_wait dropped", trig_gate, 0);
      pulse(5'b00010);
      chk("R11 B source kept", trig_gate, 1);
      finish_acq();
      wr(2, 0);
      wr(5, 0);
      wr(7, 24'hFFFFFF);
      pulse(5'b00001);
      chk("R12 address 7 has no effect", trig_gate, 1);
      finish_acq();
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc();
      t_reset();
      t_a_only();
      t_src_sel();
      t_holdoff();
      t_time_delay(4);
      t_time_delay(0);
      t_time_late();
      t_event_delay(3);
      t_event_delay(0);
      t_cfg_lock();
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         vecs++;
         errs++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

endmodule